// File: doc/BRIEF.md
# Queued SPI Interrupt and Conflict Controller

This block holds the interrupt and error-policy state for a serial engine that steps through a list of commands kept in a small local RAM. A queue sequencer reports events to it: a command finished, the command was the last one in the queue, a halt is pending, and whether the queue loops. It also reports the index of the command now running. From these events the block keeps three sticky status flags and drives a level-sensitive interrupt request.

The block also watches CPU accesses that can disturb a running queue. One case is a CPU store into the command RAM entry that is executing. The other is a CPU write that turns the engine enable off in mid-transfer. Each of these sets a flag. Policy bits then decide whether the access also gets a bus access error, in which case it is rejected. A lock bit stops software from switching the engine off at all. The engine enable bit is kept here: the CPU sets and clears it, and the sequencer clears it when the queue is done.

Top module: `qsq_irq_unit`

## Requirements
- R1: After reset the status register reads 0x0000, the engine enable `spi_en` is 0, `irq` is 0 and `acc_err` is 0.
- R2: A register write stores bits 15 (collision error enable), 14 (abort error enable), 12 (abort lock), 11 (collision interrupt enable), 10 (abort interrupt enable) and 8 (finished interrupt enable). Bits 13, 9, 7 to 4 and 1 always read 0, so writing 0xFFFF reads back 0xDD00.
- R3: Flags sit at bit 3 (collision), bit 2 (abort) and bit 0 (finished). Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R4: The finished flag sets one cycle after `cmd_done` when `end_hit` or `halt_req` is high. In that case the engine clears `spi_en`, unless looping is on and no halt is pending. A `cmd_done` with neither `end_hit` nor `halt_req` changes neither the flag nor `spi_en`.
- R5: With `wrap_mode` high, every end-of-queue completion sets the finished flag again and leaves `spi_en` at 1.
- R6: A `ram_wr` while `spi_en` is 1 and `ram_idx` equals `cur_idx` sets the collision flag. No other index pair sets it, and no write sets it while `spi_en` is 0.
- R7: On a collision with bit 15 set, `acc_err` is 1 and `ram_wr_ok` is 0 in the same cycle. With bit 15 clear, `ram_wr_ok` follows `ram_wr` and `acc_err` stays 0.
- R8: A CPU write of enable 0 while `spi_en` is 1 and the lock is off is an abort and sets the abort flag. If bit 14 is set, `acc_err` is 1 and `spi_en` stays 1. Otherwise `spi_en` clears and `acc_err` stays 0. The same write while `spi_en` is 0 sets no flag.
- R9: With the lock bit set, a CPU clear of the enable is ignored: `en_clr_ok` is 0, `spi_en` stays 1, no abort flag is set and no access error is raised. Only the engine then clears `spi_en`.
- R10: `irq` is the OR of (collision flag AND bit 11), (abort flag AND bit 10) and (finished flag AND bit 8). It stays high until the flags are cleared.
- R11: A hardware flag set and a software clear of the same flag in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | CPU write strobe for the status/control register |
| reg_wdata | input | 16 | Write data for the status/control register |
| reg_rdata | output | 16 | Current register contents |
| en_wr | input | 1 | CPU write strobe for the engine enable |
| en_wdata | input | 1 | Enable value the CPU writes |
| ram_wr | input | 1 | CPU store into the command RAM |
| ram_idx | input | IDX_W | Command RAM entry targeted by the store |
| cur_idx | input | IDX_W | Index of the command now executing |
| cmd_done | input | 1 | Sequencer: current command completed |
| end_hit | input | 1 | Sequencer: current command is the end of the queue |
| halt_req | input | 1 | Sequencer: halt requested |
| wrap_mode | input | 1 | Sequencer: queue loops at its end |
| spi_en | output | 1 | Engine enable bit |
| irq | output | 1 | Level interrupt request |
| acc_err | output | 1 | Bus access error for the current CPU access |
| ram_wr_ok | output | 1 | Command RAM store may proceed |
| en_clr_ok | output | 1 | CPU clear of the enable is accepted |

## Verification
Collision detection is swept over every pair of `cur_idx` and `ram_idx`, once with the error policy off and once with it on. The first sweep shows that only a matching pair sets the flag. The second shows that the same pairs, and only those, are refused with an access error. The interrupt output is swept over all 64 combinations of three flags and three enables, which exposes any missing or crossed term in the OR. Single runs then separate the end-of-queue, halt and ordinary completions, the looping and one-shot endings, and aborts with the lock off, with the lock on and with the error policy set. A final case puts a flag set and its clear in the same cycle.

// File: rtl/qsq_pkg.sv
// Package: bit positions and the control-field type shared by the
// queued SPI interrupt/conflict controller and its checker.
package qsq_pkg;
    localparam int REG_W    = 16;
    localparam int FLAG_N   = 3;
    // flag order inside the flag vector: 0 finished, 1 abort, 2 collision
    localparam int F_FIN    = 0;
    localparam int F_ABT    = 1;
    localparam int F_COL    = 2;
    localparam int B_FIN    = 0;
    localparam int B_ABT    = 2;
    localparam int B_COL    = 3;
    localparam int B_FIN_IE = 8;
    localparam int B_ABT_IE = 10;
    localparam int B_COL_IE = 11;
    localparam int B_LOCK   = 12;
    localparam int B_ABT_AE = 14;
    localparam int B_COL_AE = 15;

    typedef struct packed {
        logic col_ae;
        logic abt_ae;
        logic lock;
        logic col_ie;
        logic abt_ie;
        logic fin_ie;
    } ctrl_t;

    // register bit that holds flag number i
    function automatic int flag_bit(input int i);
        return (i == F_FIN) ? B_FIN : (i == F_ABT) ? B_ABT : B_COL;
    endfunction
endpackage

// File: rtl/qsq_flag.sv
// Module: one sticky status flag with write-one-to-clear.
// Assumes set and clear are single-cycle strobes; set beats clear.
module qsq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // hold the flag: reset, then set over clear
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/qsq_seq_events.sv
// Module: decodes sequencer strobes into the finished event and the
// engine's own stop request. Assumes cmd_done is a one-cycle strobe.
module qsq_seq_events (
    input  logic cmd_done,
    input  logic end_hit,
    input  logic halt_req,
    input  logic wrap_mode,
    output logic fin_evt,
    output logic hw_stop
);
    // finished on last command or halt; stop unless looping without halt
    always_comb begin
        fin_evt = cmd_done && (end_hit || halt_req);
        hw_stop = cmd_done && (halt_req || (end_hit && !wrap_mode));
    end
endmodule

// File: rtl/qsq_guard.sv
// Module: classifies CPU accesses against a running queue as collisions
// or aborts and applies the error and lock policy. Purely combinational;
// assumes at most one CPU access type per cycle is of interest.
module qsq_guard #(
    parameter int IDX_W = 4
) (
    input  logic             spi_en,
    input  logic             lock,
    input  logic             col_ae,
    input  logic             abt_ae,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             ram_wr,
    input  logic [IDX_W-1:0] ram_idx,
    input  logic [IDX_W-1:0] cur_idx,
    output logic             col_evt,
    output logic             abt_evt,
    output logic             acc_err,
    output logic             ram_wr_ok,
    output logic             en_clr_ok
);
    logic clr_req;

    // detect conflicts and decide which accesses are refused
    always_comb begin
        clr_req   = en_wr && !en_wdata;
        col_evt   = ram_wr && spi_en && (ram_idx == cur_idx);
        abt_evt   = clr_req && spi_en && !lock;
        acc_err   = (col_evt && col_ae) || (abt_evt && abt_ae);
        ram_wr_ok = ram_wr && !(col_evt && col_ae);
        en_clr_ok = clr_req && !(spi_en && (lock || abt_ae));
    end
endmodule

// File: rtl/qsq_irq_unit.sv
// Module: top of the queued SPI interrupt/conflict controller. Holds the
// control field, three sticky flags and the engine enable, and drives the
// level interrupt. Assumes sequencer strobes are synchronous to clk.
module qsq_irq_unit
    import qsq_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             ram_wr,
    input  logic [IDX_W-1:0] ram_idx,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             cmd_done,
    input  logic             end_hit,
    input  logic             halt_req,
    input  logic             wrap_mode,
    output logic             spi_en,
    output logic             irq,
    output logic             acc_err,
    output logic             ram_wr_ok,
    output logic             en_clr_ok
);
    ctrl_t             ctrl_q;
    logic [FLAG_N-1:0] flag_q;
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flag_ie;
    logic              fin_evt;
    logic              hw_stop;
    logic              col_evt;
    logic              abt_evt;

    qsq_seq_events i_events (
        .cmd_done  (cmd_done),
        .end_hit   (end_hit),
        .halt_req  (halt_req),
        .wrap_mode (wrap_mode),
        .fin_evt   (fin_evt),
        .hw_stop   (hw_stop)
    );

    qsq_guard #(.IDX_W(IDX_W)) i_guard (
        .spi_en    (spi_en),
        .lock      (ctrl_q.lock),
        .col_ae    (ctrl_q.col_ae),
        .abt_ae    (ctrl_q.abt_ae),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .ram_wr    (ram_wr),
        .ram_idx   (ram_idx),
        .cur_idx   (cur_idx),
        .col_evt   (col_evt),
        .abt_evt   (abt_evt),
        .acc_err   (acc_err),
        .ram_wr_ok (ram_wr_ok),
        .en_clr_ok (en_clr_ok)
    );

    // gather per-flag set events and interrupt enables
    always_comb begin
        flag_set        = '0;
        flag_set[F_FIN] = fin_evt;
        flag_set[F_ABT] = abt_evt;
        flag_set[F_COL] = col_evt;
        flag_ie         = {ctrl_q.col_ie, ctrl_q.abt_ie, ctrl_q.fin_ie};
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        qsq_flag i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[i]),
            .clr_i (reg_wr && reg_wdata[flag_bit(i)]),
            .q_o   (flag_q[i])
        );
    end

    // control field: loaded whole on a register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr) begin
            ctrl_q <= '{col_ae: reg_wdata[B_COL_AE], abt_ae: reg_wdata[B_ABT_AE],
                        lock:   reg_wdata[B_LOCK],   col_ie: reg_wdata[B_COL_IE],
                        abt_ie: reg_wdata[B_ABT_IE], fin_ie: reg_wdata[B_FIN_IE]};
        end
    end

    // engine enable: engine stop first, then CPU set, then accepted CPU clear
    always_ff @(posedge clk) begin
        if (!rst_n)                spi_en <= 1'b0;
        else if (hw_stop)          spi_en <= 1'b0;
        else if (en_wr && en_wdata) spi_en <= 1'b1;
        else if (en_clr_ok)        spi_en <= 1'b0;
    end

    // read view with reserved bits forced to zero
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[B_COL_AE] = ctrl_q.col_ae;
        reg_rdata[B_ABT_AE] = ctrl_q.abt_ae;
        reg_rdata[B_LOCK]   = ctrl_q.lock;
        reg_rdata[B_COL_IE] = ctrl_q.col_ie;
        reg_rdata[B_ABT_IE] = ctrl_q.abt_ie;
        reg_rdata[B_FIN_IE] = ctrl_q.fin_ie;
        reg_rdata[B_COL]    = flag_q[F_COL];
        reg_rdata[B_ABT]    = flag_q[F_ABT];
        reg_rdata[B_FIN]    = flag_q[F_FIN];
    end

    // level interrupt from enabled flags
    always_comb irq = |(flag_q & flag_ie);
endmodule

// File: rtl/qsq_irq_chk.sv
// Module: assertion checker for qsq_irq_unit, attached by bind below.
// Works only from the top module's ports.
module qsq_irq_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      reg_rdata,
    input logic             en_wr,
    input logic             en_wdata,
    input logic             ram_wr,
    input logic [IDX_W-1:0] ram_idx,
    input logic [IDX_W-1:0] cur_idx,
    input logic             cmd_done,
    input logic             end_hit,
    input logic             halt_req,
    input logic             spi_en,
    input logic             irq,
    input logic             acc_err,
    input logic             ram_wr_ok
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 16'h22F2) == 16'h0000); // R2

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((reg_rdata[3] && reg_rdata[11]) || (reg_rdata[2] && reg_rdata[10])
                || (reg_rdata[0] && reg_rdata[8]))); // R10

    AST_FIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done && (end_hit || halt_req) |=> reg_rdata[0]); // R4

    AST_COL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr && spi_en && (ram_idx == cur_idx) |=> reg_rdata[3]); // R6

    AST_COL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr && spi_en && (ram_idx == cur_idx) && reg_rdata[15]
        |-> acc_err && !ram_wr_ok); // R7

    AST_ABT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr && !en_wdata && spi_en && !reg_rdata[12] && reg_rdata[14]
        |-> acc_err); // R8

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr && !en_wdata && spi_en && reg_rdata[12] && !cmd_done
        |=> spi_en); // R9
endmodule

bind qsq_irq_unit qsq_irq_chk #(.IDX_W(IDX_W)) i_qsq_irq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .ram_wr    (ram_wr),
    .ram_idx   (ram_idx),
    .cur_idx   (cur_idx),
    .cmd_done  (cmd_done),
    .end_hit   (end_hit),
    .halt_req  (halt_req),
    .spi_en    (spi_en),
    .irq       (irq),
    .acc_err   (acc_err),
    .ram_wr_ok (ram_wr_ok)
);

// File: tb/test_qsq_irq_unit.sv
`timescale 1ns/1ps
module test_qsq_irq_unit;
    localparam int IDX_W = 4;
    localparam int NIDX  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic             en_wr = 1'b0, en_wdata = 1'b0;
    logic             ram_wr = 1'b0;
    logic [IDX_W-1:0] ram_idx = '0, cur_idx = '0;
    logic             cmd_done = 1'b0, end_hit = 1'b0, halt_req = 1'b0, wrap_mode = 1'b0;
    logic             spi_en, irq, acc_err, ram_wr_ok, en_clr_ok;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    qsq_irq_unit #(.IDX_W(IDX_W)) i_qsq_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .en_wr(en_wr), .en_wdata(en_wdata),
        .ram_wr(ram_wr), .ram_idx(ram_idx), .cur_idx(cur_idx),
        .cmd_done(cmd_done), .end_hit(end_hit), .halt_req(halt_req),
        .wrap_mode(wrap_mode), .spi_en(spi_en), .irq(irq), .acc_err(acc_err),
        .ram_wr_ok(ram_wr_ok), .en_clr_ok(en_clr_ok)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // all calls start and end just after a falling edge
    task automatic wr_reg(input logic [15:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic start_en();
        en_wr = 1'b1; en_wdata = 1'b1;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic done(input logic e, input logic h);
        cmd_done = 1'b1; end_hit = e; halt_req = h;
        @(negedge clk);
        cmd_done = 1'b0; end_hit = 1'b0; halt_req = 1'b0;
    endtask

    task automatic try_clear(output logic err, output logic ok);
        en_wr = 1'b1; en_wdata = 1'b0;
        #1 err = acc_err; ok = en_clr_ok;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic e, ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(reg_rdata == 16'h0 && !spi_en && !irq && !acc_err, "R1 reset",
            {reg_rdata, spi_en, irq, acc_err}, 0);
        @(negedge clk);

        // R2 control storage and reserved bits
        wr_reg(16'hFFFF);
        chk(reg_rdata == 16'hDD00, "R2 write all ones", reg_rdata, 16'hDD00);
        wr_reg(16'h0000);
        chk(reg_rdata == 16'h0000, "R2 write zero", reg_rdata, 0);

        // R6 / R7 collision sweep over all index pairs, policy off then on
        start_en();
        for (int ae = 0; ae < 2; ae++) begin
            for (int a = 0; a < NIDX; a++) begin
                for (int b = 0; b < NIDX; b++) begin
                    logic [15:0] base;
                    base = (ae != 0) ? 16'h8000 : 16'h0000;
                    wr_reg(base | 16'h0008);
                    cur_idx = a[IDX_W-1:0]; ram_idx = b[IDX_W-1:0]; ram_wr = 1'b1;
                    #1;
                    chk(acc_err == (ae != 0 && a == b), "R7 acc_err on store", acc_err,
                        (ae != 0 && a == b));
                    chk(ram_wr_ok == !(ae != 0 && a == b), "R7 store gate", ram_wr_ok,
                        !(ae != 0 && a == b));
                    @(negedge clk);
                    ram_wr = 1'b0;
                    chk(reg_rdata[3] == (a == b), "R6 collision flag", reg_rdata[3], (a == b));
                end
            end
        end
        chk(spi_en, "R6 enable kept during stores", spi_en, 1);
        // R6 no collision while idle
        wr_reg(16'h000D);
        done(1'b1, 1'b0);
        cur_idx = 3; ram_idx = 3; ram_wr = 1'b1;
        @(negedge clk);
        ram_wr = 1'b0;
        chk(!spi_en && reg_rdata[3] == 1'b0, "R6 idle store no flag", reg_rdata[3], 0);

        // R10 interrupt sweep: flags x enables
        wrap_mode = 1'b1;
        for (int f = 0; f < 8; f++) begin
            for (int en = 0; en < 8; en++) begin
                logic [15:0] ie;
                logic        exp_irq;
                ie = {4'b0, en[2], en[1], 1'b0, en[0], 8'h00};
                wr_reg(ie | 16'h000D);
                start_en();
                if (f[1]) begin try_clear(e, ok); start_en(); end
                if (f[2]) begin cur_idx = 5; ram_idx = 5; ram_wr = 1'b1;
                                @(negedge clk); ram_wr = 1'b0; end
                if (f[0]) done(1'b1, 1'b0);
                exp_irq = (f[2] & en[2]) | (f[1] & en[1]) | (f[0] & en[0]);
                chk({reg_rdata[3], reg_rdata[2], reg_rdata[0]} == f[2:0], "R10 flags set",
                    {reg_rdata[3], reg_rdata[2], reg_rdata[0]}, f);
                chk(irq == exp_irq, "R10 irq", irq, exp_irq);
                @(negedge clk);
                chk(irq == exp_irq, "R10 irq level held", irq, exp_irq);
            end
        end

        // R3 zero writes leave flags, ones clear only their bit
        wr_reg(16'h0900);
        chk(reg_rdata[3] && reg_rdata[2] && reg_rdata[0], "R3 zero write keeps",
            reg_rdata[3:0], 4'hD);
        wr_reg(16'h0904);
        chk(reg_rdata[3:0] == 4'h9, "R3 clear abort only", reg_rdata[3:0], 4'h9);
        chk(irq, "R10 irq while collision flag", irq, 1);
        wr_reg(16'h0909);
        chk(reg_rdata[3:0] == 4'h0 && !irq, "R3 clear rest", reg_rdata[3:0], 0);

        // R4 completion kinds, one-shot
        wrap_mode = 1'b0;
        wr_reg(16'h000D);
        if (!spi_en) start_en();
        done(1'b0, 1'b0);
        chk(!reg_rdata[0] && spi_en, "R4 plain completion", {reg_rdata[0], spi_en}, 1);
        halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
        chk(!reg_rdata[0] && spi_en, "R4 halt without completion",
            {reg_rdata[0], spi_en}, 1);
        done(1'b1, 1'b0);
        chk(reg_rdata[0] && !spi_en, "R4 end of queue", {reg_rdata[0], spi_en}, 2);
        wr_reg(16'h0001);
        start_en();
        done(1'b0, 1'b1);
        chk(reg_rdata[0] && !spi_en, "R4 halt completion", {reg_rdata[0], spi_en}, 2);

        // R5 looping queue
        wrap_mode = 1'b1;
        wr_reg(16'h0001);
        start_en();
        done(1'b1, 1'b0);
        chk(reg_rdata[0] && spi_en, "R5 wrap first pass", {reg_rdata[0], spi_en}, 3);
        wr_reg(16'h0001);
        chk(!reg_rdata[0], "R5 cleared between passes", reg_rdata[0], 0);
        done(1'b1, 1'b0);
        chk(reg_rdata[0] && spi_en, "R5 wrap second pass", {reg_rdata[0], spi_en}, 3);
        done(1'b1, 1'b1);
        chk(!spi_en, "R5 halt ends looping", spi_en, 0);
        wrap_mode = 1'b0;

        // R8 abort, policy off
        wr_reg(16'h000D);
        start_en();
        try_clear(e, ok);
        chk(!e && ok, "R8 abort no error", {e, ok}, 1);
        chk(reg_rdata[2] && !spi_en, "R8 abort clears", {reg_rdata[2], spi_en}, 2);
        // R8 abort, policy on
        wr_reg(16'h4004);
        start_en();
        try_clear(e, ok);
        chk(e && !ok, "R8 abort refused", {e, ok}, 2);
        chk(reg_rdata[2] && spi_en, "R8 abort keeps enable", {reg_rdata[2], spi_en}, 3);
        // R8 clear while idle is no abort
        done(1'b1, 1'b0);
        wr_reg(16'h0004);
        try_clear(e, ok);
        chk(!reg_rdata[2] && !e, "R8 idle clear no flag", {reg_rdata[2], e}, 0);

        // R9 lock: clear ignored, engine still stops
        wr_reg(16'h5000);
        start_en();
        try_clear(e, ok);
        chk(!e && !ok, "R9 locked clear refused quietly", {e, ok}, 0);
        chk(spi_en && !reg_rdata[2], "R9 enable held no abort", {spi_en, reg_rdata[2]}, 2);
        done(1'b1, 1'b0);
        chk(!spi_en, "R9 engine stop under lock", spi_en, 0);

        // R11 set beats same-cycle clear
        wr_reg(16'h0001);
        start_en();
        cmd_done = 1'b1; end_hit = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0001;
        @(negedge clk);
        cmd_done = 1'b0; end_hit = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        chk(reg_rdata[0], "R11 set wins", reg_rdata[0], 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule